// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

A register-mapped watchdog for a system bus with single-cycle 32-bit register reads and writes. Software loads a tick count into the timer register. The count is the clock rate multiplied by the wanted timeout in seconds. Software then picks one of four expiry actions in the control register. While an action is selected, the count falls by one every clock. Writing the timer again reloads it, and that write is the keep-alive.

When the count reaches zero, the block drives exactly one output, chosen by the action. A general-purpose interrupt and a non-maskable interrupt are held levels. A chip-reset request is a one-clock pulse. A sticky cause flag records that the watchdog issued a reset request. The chip reset that follows does not clear the flag; only the power-on reset does. This lets boot code tell a watchdog reset apart from a cold start.

Top module: `wdt_action_timer`

## Requirements
- R1: After power-on reset, the control register (offset 0x0) reads 0x00000000, the timer register (offset 0x4) reads 0xFFFFFFFF, and irq_o, nmi_o and rst_req_o are low.
- R2: A write to offset 0x0 sets the action field from write data bits [1:0] (0 off, 1 interrupt, 2 non-maskable interrupt, 3 reset request). A read of offset 0x0 returns the action in bits [1:0], the cause flag in bit 31 and zero elsewhere. Write data bit 31 has no effect.
- R3: A write to offset 0x4 loads the count in that clock with no decrement. A read of offset 0x4 returns the live count, and rewriting it before expiry postpones expiry.
- R4: While the action is nonzero, the count falls by one each clock and holds at zero. While the action is 0, the count holds.
- R5: With action 1, irq_o is high in every cycle the count is zero. It stays high until a nonzero reload or a change of action.
- R6: With action 2, nmi_o behaves as irq_o does under R5.
- R7: With action 3, rst_req_o is high for exactly one cycle when the count reaches zero. It pulses again only after a new register write.
- R8: The cause flag (control bit 31) is set in the cycle after a reset request. It survives rst_n and is cleared only by por_n.
- R9: rst_n low clears the action to 0 and sets the count to 0xFFFFFFFF.
- R10: Writes to offsets other than 0x0 and 0x4 change no register, and reads of such offsets return 0.
- R11: At most one of irq_o, nmi_o and rst_req_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low chip reset; keeps the cause flag |
| por_n | input | 1 | Synchronous active-low power-on reset; clears everything |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | General-purpose interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| rst_req_o | output | 1 | One-cycle chip-reset request |

## Verification
A wrong count shows within one cycle in the timer readback. It also shifts the expiry output by the same number of cycles, so the bench samples outputs at the exact expiry cycle and at points just before and after it. A stuck or lost fired state appears as a reset pulse that lasts more than one cycle or never comes. A cause flag cleared by the wrong reset appears as bit 31 of the control readback, in the first read after that reset.

// File: rtl/wdt_pkg.sv
// Package: shared encodings and register offsets for the watchdog.
// Assumes byte offsets on the register bus and a data width of at least 2 bits.
package wdt_pkg;
    typedef enum logic [1:0] {
        ACT_OFF = 2'd0,
        ACT_IRQ = 2'd1,
        ACT_NMI = 2'd2,
        ACT_RST = 2'd3
    } wdt_act_e;

    localparam int WDT_NUM_ACT   = 4;
    localparam int WDT_OFF_CTRL  = 0;
    localparam int WDT_OFF_TIMER = 4;
endpackage

// File: rtl/wdt_regs.sv
// Register file: decodes single-cycle bus accesses, holds the action field and
// the sticky cause flag, and muxes read data. Assumes the read data is used
// combinationally in the access cycle. The cause flag sits in the top data bit.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_i,
    input  logic              rst_req_i,
    output wdt_act_e          action_o,
    output logic              cause_o,
    output logic              ctrl_wr_o,
    output logic              timer_wr_o,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int CAUSE_BIT = DATA_W - 1;

    logic hit_ctrl;
    logic hit_timer;

    assign hit_ctrl   = (bus_addr == ADDR_W'(WDT_OFF_CTRL));
    assign hit_timer  = (bus_addr == ADDR_W'(WDT_OFF_TIMER));
    assign ctrl_wr_o  = bus_sel && bus_wr && hit_ctrl;
    assign timer_wr_o = bus_sel && bus_wr && hit_timer;

    // Action field: cleared by either reset, written from data bits [1:0].
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            action_o <= ACT_OFF;
        end else if (ctrl_wr_o) begin
            action_o <= wdt_act_e'(bus_wdata[1:0]);
        end
    end

    // Cause flag: set by a reset request, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_o <= 1'b0;
        end else if (rst_req_i) begin
            cause_o <= 1'b1;
        end
    end

    // Read mux: control layout, live count, or zero for unused offsets.
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[CAUSE_BIT] = cause_o;
            bus_rdata[1:0]       = action_o;
        end else if (hit_timer) begin
            bus_rdata = count_i;
        end
    end
endmodule

// File: rtl/wdt_down_counter.sv
// Down counter: loads on request, otherwise counts down while enabled and
// saturates at zero. Assumes a load takes priority over counting in a cycle.
module wdt_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);
    assign zero_o = (count_o == '0);

    // Count register: reset to all ones, load, or decrement toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '1;
        end else if (load_i) begin
            count_o <= load_val_i;
        end else if (run_i && !zero_o) begin
            count_o <= count_o - 1'b1;
        end
    end
endmodule

// File: rtl/wdt_expiry_outputs.sv
// Expiry output stage: turns zero-count plus action into one of three outputs.
// The interrupt levels follow the state. The reset request fires once and is
// re-armed by any register write. Assumes zero_i comes from a register.
module wdt_expiry_outputs
    import wdt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  wdt_act_e action_i,
    input  logic     zero_i,
    input  logic     rearm_i,
    output logic     irq_o,
    output logic     nmi_o,
    output logic     rst_req_o
);
    logic [WDT_NUM_ACT-1:1] hit;
    logic                   fired;

    // One decode per non-off action code.
    for (genvar g = 1; g < WDT_NUM_ACT; g++) begin : g_hit
        assign hit[g] = zero_i && (action_i == wdt_act_e'(g));
    end

    assign irq_o     = hit[ACT_IRQ];
    assign nmi_o     = hit[ACT_NMI];
    assign rst_req_o = hit[ACT_RST] && !fired;

    // Fired flag: remembers the issued reset request until the next write.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm_i) begin
            fired <= 1'b0;
        end else if (rst_req_o) begin
            fired <= 1'b1;
        end
    end
endmodule

// File: rtl/wdt_action_timer.sv
// Top: watchdog with software-selected expiry action on a single-cycle
// register bus. Assumes rst_n and por_n are synchronous to clk.
module wdt_action_timer
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              rst_req_o
);
    logic              core_rst_n;
    wdt_act_e          action_q;
    logic              cause_q;
    logic              ctrl_wr;
    logic              timer_wr;
    logic [DATA_W-1:0] count_q;
    logic              count_zero;

    assign core_rst_n = rst_n && por_n;

    wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .core_rst_n (core_rst_n),
        .por_n      (por_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count_i    (count_q),
        .rst_req_i  (rst_req_o),
        .action_o   (action_q),
        .cause_o    (cause_q),
        .ctrl_wr_o  (ctrl_wr),
        .timer_wr_o (timer_wr),
        .bus_rdata  (bus_rdata)
    );

    wdt_down_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .load_i     (timer_wr),
        .load_val_i (bus_wdata),
        .run_i      (action_q != ACT_OFF),
        .count_o    (count_q),
        .zero_o     (count_zero)
    );

    wdt_expiry_outputs u_out (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .action_i  (action_q),
        .zero_i    (count_zero),
        .rearm_i   (ctrl_wr || timer_wr),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );
endmodule

// File: rtl/wdt_action_timer_chk.sv
// Checker: temporal properties of the watchdog, bound to the top module.
module wdt_action_timer_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              irq_o,
    input logic              nmi_o,
    input logic              rst_req_o,
    input logic [DATA_W-1:0] count_q,
    input logic [1:0]        action_q,
    input logic              cause_q
);
    logic any_wr;
    assign any_wr = bus_sel && bus_wr;

    assert_one_output_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $onehot0({irq_o, nmi_o, rst_req_o}));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (rst_req_o && !any_wr) |=> !rst_req_o);

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (action_q != 2'd0 && count_q != '0 && !any_wr) |=> (count_q == $past(count_q) - 1'b1));

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (count_q == '0 && !any_wr) |=> (count_q == '0));

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (irq_o && !any_wr) |=> irq_o);

    assert_nmi_level_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (nmi_o && !any_wr) |=> nmi_o);

    assert_cause_set_R8: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> cause_q);

    assert_cause_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
        cause_q |=> cause_q);
endmodule

bind wdt_action_timer wdt_action_timer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o),
    .rst_req_o (rst_req_o),
    .count_q   (count_q),
    .action_q  (action_q),
    .cause_q   (cause_q)
);

// File: tb/wdt_action_timer_bench.sv
module wdt_action_timer_bench;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam int NV = 10;
    localparam int VW = 77;

    // {action(2), load(32), wait(8), expected count(32), expected {irq,nmi,rst}(3)}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd1, 32'd5, 8'd3,  32'd2, 3'b000},
        {2'd1, 32'd5, 8'd5,  32'd0, 3'b100},
        {2'd1, 32'd5, 8'd9,  32'd0, 3'b100},
        {2'd2, 32'd4, 8'd4,  32'd0, 3'b010},
        {2'd2, 32'd7, 8'd2,  32'd5, 3'b000},
        {2'd0, 32'd6, 8'd10, 32'd6, 3'b000},
        {2'd3, 32'd3, 8'd3,  32'd0, 3'b001},
        {2'd3, 32'd3, 8'd4,  32'd0, 3'b000},
        {2'd1, 32'd0, 8'd0,  32'd0, 3'b100},
        {2'd3, 32'd0, 8'd0,  32'd0, 3'b001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;
    logic          nmi_o;
    logic          rst_req_o;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    wdt_action_timer #(.DATA_W(DW), .ADDR_W(AW)) u_wdt_action_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [DW-1:0] outs();
        return {29'd0, irq_o, nmi_o, rst_req_o};
    endfunction

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int pulses;
        idle(3);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1: power-on state
        bus_read(3'h0, rd); check("R1 ctrl", rd, 32'h0);
        bus_read(3'h4, rd); check("R1 timer", rd, 32'hFFFF_FFFF);
        check("R1 outputs", outs(), 32'h0);

        // R2: write with bit 31 set; only the action field takes effect
        bus_write(3'h0, 32'h8000_0002);
        bus_read(3'h0, rd); check("R2 ctrl readback", rd, 32'h0000_0002);

        // R10: unused offsets are ignored and read zero
        bus_write(3'h0, 32'h0);
        bus_write(3'h4, 32'h100);
        bus_write(3'h6, 32'h3);
        bus_write(3'h2, 32'h55);
        bus_read(3'h0, rd); check("R10 ctrl unchanged", rd, 32'h0);
        bus_read(3'h4, rd); check("R10 timer unchanged", rd, 32'h100);
        bus_read(3'h6, rd); check("R10 unused read", rd, 32'h0);

        // Table walk: R4 R5 R6 R7 R11
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            bus_write(3'h0, 32'h0);
            bus_write(3'h4, v[74:43]);
            bus_write(3'h0, {30'd0, v[76:75]});
            idle(int'(v[42:35]));
            bus_read(3'h4, rd);
            check($sformatf("R4 table %0d count", i), rd, v[34:3]);
            check($sformatf("R5 R6 R7 R11 table %0d outputs", i), outs(), {29'd0, v[2:0]});
        end

        // R3: live readback and keep-alive postpones expiry
        bus_write(3'h0, 32'h0);
        bus_write(3'h4, 32'd20);
        bus_write(3'h0, 32'h1);
        idle(4);
        bus_read(3'h4, rd); check("R3 live count", rd, 32'd16);
        bus_write(3'h4, 32'd5);
        bus_read(3'h4, rd); check("R3 reload no decrement", rd, 32'd5);
        idle(3);
        bus_write(3'h4, 32'd5);
        idle(3);
        bus_read(3'h4, rd); check("R3 keep-alive count", rd, 32'd2);
        check("R3 keep-alive no irq", outs(), 32'h0);

        // R5: interrupt level cleared by nonzero reload, then by action 0
        idle(2);
        check("R5 irq at zero", outs(), 32'h4);
        bus_write(3'h4, 32'd9);
        check("R5 irq cleared by reload", outs(), 32'h0);
        idle(9);
        check("R5 irq again", outs(), 32'h4);
        bus_write(3'h0, 32'h0);
        check("R5 irq cleared by action 0", outs(), 32'h0);

        // R7: exactly one reset pulse per expiry
        bus_write(3'h4, 32'd2);
        bus_write(3'h0, 32'h3);
        pulses = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rst_req_o) pulses++;
        end
        check("R7 pulse count", 32'(pulses), 32'd1);

        // R8: cause flag set, survives chip reset
        bus_read(3'h0, rd); check("R8 cause after request", rd, 32'h8000_0003);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(3'h0, rd); check("R8 R9 ctrl after chip reset", rd, 32'h8000_0000);
        bus_read(3'h4, rd); check("R9 timer after chip reset", rd, 32'hFFFF_FFFF);
        idle(3);
        bus_read(3'h4, rd); check("R9 timer holds with action 0", rd, 32'hFFFF_FFFF);
        check("R9 outputs after chip reset", outs(), 32'h0);

        // R8: only power-on reset clears the flag
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        bus_read(3'h0, rd); check("R8 cause cleared by por", rd, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule